// File: doc/BRIEF.md
# Dual-Port Memory with Collision Marking

This block is a synchronous memory with two fully independent access ports, A and B, that share one clock. Each port can write a word or read one back, and read data appears one clock after the address is presented. A clock enable stops all writes and all changes to the corruption state. It never stops the read path.

When both ports write the same word in the same enabled cycle, the stored result would be ill-defined. The block therefore stores an all-zero word at that address and marks the word as corrupt. It also pulses a collision flag together with the address. While a word stays marked, any port that reads it gets a one-cycle warning pulse carrying that address, in the same cycle as the read data. A later write from a single port makes the word clean again.

The word width comes from a numeric-format parameter, an integer-bit count and a fractional-bit count. The fractional bits count only in signed fractional format. Depth is two to the power of the address-width parameter.

Top module: `tdpr_dual_ram`

## Requirements
- R1: Each port returns the word stored at its address on its read-data output one clock edge after the address is presented, and both ports read independently in the same cycle.
- R2: When a port writes an address, its read-data output on the next cycle shows the word held there before that write. The new word appears on a later read.
- R3: While `clk_en` is low, no write changes memory, no mark is set or cleared and no collision pulse occurs. Read data and corrupt-read pulses are still delivered.
- R4: Enabled writes from one port, or from both ports to different addresses, store their data unchanged and never mark a word corrupt.
- R5: When both ports write the same address in one enabled cycle, that word afterwards reads as all zeros, whatever data either port offered.
- R6: `clash_pulse` is high for exactly the cycle after such a same-address dual write, with `clash_addr` equal to that address. Otherwise `clash_pulse` is 0 and `clash_addr` is 0.
- R7: A port that is not writing, and that reads a word marked corrupt, raises its own taint pulse (`a_taint_pulse` or `b_taint_pulse`) in the cycle its read data appears. Its taint address carries the read address. When the pulse is 0, the taint address is 0.
- R8: An enabled write of a marked word that does not collide clears the mark. From the next cycle on, reads of that word raise no taint pulse and return the new data.
- R9: A port that writes in an enabled cycle raises no taint pulse for that cycle, even when the address it writes is marked.
- R10: While `rst_n` is low, all read-data outputs, pulses and addresses are 0. After reset no word is marked, though the stored data is kept.
- R11: The data ports are INT_BITS+FRAC_BITS wide in signed fractional format (FMT=2) and INT_BITS wide in the integer formats (0 signed, 1 unsigned). The default is signed fractional with 8+8 bits, which gives 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Enables writes and mark updates |
| a_wdata | input | W | Port A write data |
| a_addr | input | ADDR_W | Port A address, unsigned |
| a_we | input | 1 | Port A write enable |
| b_wdata | input | W | Port B write data |
| b_addr | input | ADDR_W | Port B address, unsigned |
| b_we | input | 1 | Port B write enable |
| a_rdata | output | W | Port A read data |
| b_rdata | output | W | Port B read data |
| clash_pulse | output | 1 | Same-address dual write happened |
| clash_addr | output | ADDR_W | Address of that dual write |
| a_taint_pulse | output | 1 | Port A read a corrupt word |
| a_taint_addr | output | ADDR_W | Address of that corrupt read on A |
| b_taint_pulse | output | 1 | Port B read a corrupt word |
| b_taint_addr | output | ADDR_W | Address of that corrupt read on B |

## Verification
The bench targets these corner cases:

- A dual write to the same word. A design that let either port win would return that port's data instead of zero.
- The cycle after a collision, when one port rewrites the marked word while the other reads it. The reader must still see the old mark and the writer must stay silent. A design that updated the mark before the lookup, or flagged write cycles, would miss the first pulse or raise the second.
- A collision attempted with the clock enable low. It must leave no trace, while reads still flow.
- A reset in the middle of a run, which must clear all marks but keep the data.
- A random run confined to four addresses, which produces dense collisions, rewrites and corrupt reads on both ports.

// File: rtl/tdpr_pkg.sv
package tdpr_pkg;

   typedef enum logic [1:0] {
      FMT_SINT  = 2'd0,
      FMT_UINT  = 2'd1,
      FMT_SFRAC = 2'd2
   } num_fmt_e;

   // Stored word width: fraction bits only count for signed fractional format
   function automatic int word_width(num_fmt_e fmt, int int_bits, int frac_bits);
      return (fmt == FMT_SFRAC) ? (int_bits + frac_bits) : int_bits;
   endfunction

endpackage

// File: rtl/tdpr_clash_detect.sv
module tdpr_clash_detect #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              a_we,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              wr_a,
   output logic              wr_b,
   output logic              clash,
   output logic              clash_pulse,
   output logic [ADDR_W-1:0] clash_addr
);

   logic same_addr;

   always_comb begin
      wr_a      = clk_en & a_we;
      wr_b      = clk_en & b_we;
      same_addr = (a_addr == b_addr);
      clash     = wr_a & wr_b & same_addr;
   end

   // Report registered so it lines up with read data of the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clash_pulse <= 1'b0;
         clash_addr  <= '0;
      end else begin
         clash_pulse <= clash;
         clash_addr  <= clash ? a_addr : '0;
      end
   end

endmodule

// File: rtl/tdpr_taint_map.sv
module tdpr_taint_map #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic              clash,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              a_taint_pulse,
   output logic [ADDR_W-1:0] a_taint_addr,
   output logic              b_taint_pulse,
   output logic [ADDR_W-1:0] b_taint_addr
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0] mark_q;
   logic [DEPTH-1:0] mark_d;

   // Per-word next-state: collision sets, any other enabled write clears
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
      logic hit_a;
      logic hit_b;
      always_comb begin
         hit_a = wr_a && (a_addr == ADDR_W'(gi));
         hit_b = wr_b && (b_addr == ADDR_W'(gi));
         if (clash && hit_a)
            mark_d[gi] = 1'b1;
         else if (hit_a || hit_b)
            mark_d[gi] = 1'b0;
         else
            mark_d[gi] = mark_q[gi];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mark_q <= '0;
      else        mark_q <= mark_d;
   end

   // Lookup uses the mark as it stood before this cycle's update
   logic flag_a;
   logic flag_b;

   always_comb begin
      flag_a = !wr_a && mark_q[a_addr];
      flag_b = !wr_b && mark_q[b_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_taint_pulse <= 1'b0;
         a_taint_addr  <= '0;
         b_taint_pulse <= 1'b0;
         b_taint_addr  <= '0;
      end else begin
         a_taint_pulse <= flag_a;
         a_taint_addr  <= flag_a ? a_addr : '0;
         b_taint_pulse <= flag_b;
         b_taint_addr  <= flag_b ? b_addr : '0;
      end
   end

endmodule

// File: rtl/tdpr_word_store.sv
module tdpr_word_store #(
   parameter int W      = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic              clash,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [W-1:0]      a_wdata,
   input  logic [W-1:0]      b_wdata,
   output logic [W-1:0]      a_rdata,
   output logic [W-1:0]      b_rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [W-1:0] mem [DEPTH];

   // A collision stores the zero substitute through port A; B is suppressed
   always_ff @(posedge clk) begin
      if (wr_a)
         mem[a_addr] <= clash ? '0 : a_wdata;
      if (wr_b && !clash)
         mem[b_addr] <= b_wdata;
   end

   // Read register is never gated by the clock enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         a_rdata <= mem[a_addr];
         b_rdata <= mem[b_addr];
      end
   end

endmodule

// File: rtl/tdpr_dual_ram.sv
module tdpr_dual_ram
   import tdpr_pkg::*;
#(
   parameter num_fmt_e FMT       = FMT_SFRAC,
   parameter int       INT_BITS  = 8,
   parameter int       FRAC_BITS = 8,
   parameter int       ADDR_W    = 5,
   localparam int      W         = word_width(FMT, INT_BITS, FRAC_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic [W-1:0]      a_wdata,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_we,
   input  logic [W-1:0]      b_wdata,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_we,
   output logic [W-1:0]      a_rdata,
   output logic [W-1:0]      b_rdata,
   output logic              clash_pulse,
   output logic [ADDR_W-1:0] clash_addr,
   output logic              a_taint_pulse,
   output logic [ADDR_W-1:0] a_taint_addr,
   output logic              b_taint_pulse,
   output logic [ADDR_W-1:0] b_taint_addr
);

   // Elaboration-time parameter checks
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("tdpr_dual_ram: ADDR_W must be at least 1");
   end
   if (INT_BITS < 1) begin : g_bad_int_bits
      $error("tdpr_dual_ram: INT_BITS must be at least 1");
   end
   if (FRAC_BITS < 0) begin : g_bad_frac_bits
      $error("tdpr_dual_ram: FRAC_BITS must not be negative");
   end
   if (W < 1) begin : g_bad_width
      $error("tdpr_dual_ram: derived word width must be positive");
   end

   logic wr_a;
   logic wr_b;
   logic clash;

   tdpr_clash_detect #(
      .ADDR_W (ADDR_W)
   ) clash_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_en      (clk_en),
      .a_we        (a_we),
      .b_we        (b_we),
      .a_addr      (a_addr),
      .b_addr      (b_addr),
      .wr_a        (wr_a),
      .wr_b        (wr_b),
      .clash       (clash),
      .clash_pulse (clash_pulse),
      .clash_addr  (clash_addr)
   );

   tdpr_word_store #(
      .W      (W),
      .ADDR_W (ADDR_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_a    (wr_a),
      .wr_b    (wr_b),
      .clash   (clash),
      .a_addr  (a_addr),
      .b_addr  (b_addr),
      .a_wdata (a_wdata),
      .b_wdata (b_wdata),
      .a_rdata (a_rdata),
      .b_rdata (b_rdata)
   );

   tdpr_taint_map #(
      .ADDR_W (ADDR_W)
   ) taint_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_a          (wr_a),
      .wr_b          (wr_b),
      .clash         (clash),
      .a_addr        (a_addr),
      .b_addr        (b_addr),
      .a_taint_pulse (a_taint_pulse),
      .a_taint_addr  (a_taint_addr),
      .b_taint_pulse (b_taint_pulse),
      .b_taint_addr  (b_taint_addr)
   );

endmodule

// File: rtl/tdpr_dual_ram_chk.sv
module tdpr_dual_ram_chk #(
   parameter int W      = 16,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_we,
   input logic [ADDR_W-1:0] b_addr,
   input logic              b_we,
   input logic [W-1:0]      a_rdata,
   input logic              clash_pulse,
   input logic [ADDR_W-1:0] clash_addr,
   input logic              a_taint_pulse,
   input logic [ADDR_W-1:0] a_taint_addr,
   input logic              b_taint_pulse,
   input logic [ADDR_W-1:0] b_taint_addr
);

   logic dual_same;
   assign dual_same = clk_en && a_we && b_we && (a_addr == b_addr);

   // R6
   p_clash_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dual_same |=> (clash_pulse && clash_addr == $past(a_addr)));

   // R6
   p_no_false_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dual_same |=> (!clash_pulse && clash_addr == '0));

   // R3
   p_enable_low_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> !clash_pulse);

   // R5 and R7: the read after a collision returns zero and is flagged
   p_zero_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dual_same ##1 (!(clk_en && a_we) && a_addr == $past(a_addr))
      |=> (a_rdata == '0 && a_taint_pulse));

   // R7
   p_taint_addr_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !a_taint_pulse |-> a_taint_addr == '0);

   // R7
   p_taint_addr_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !b_taint_pulse |-> b_taint_addr == '0);

   // R9
   p_a_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && a_we) |=> !a_taint_pulse);

   // R9
   p_b_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && b_we) |=> !b_taint_pulse);

   // R8: a clean write on A followed by a read of the same word is not flagged
   p_clean_rewrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && a_we && !(b_we && b_addr == a_addr))
      ##1 (!(clk_en && a_we) && a_addr == $past(a_addr))
      |=> !a_taint_pulse);

endmodule

bind tdpr_dual_ram tdpr_dual_ram_chk #(
   .W      (W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .clk_en        (clk_en),
   .a_addr        (a_addr),
   .a_we          (a_we),
   .b_addr        (b_addr),
   .b_we          (b_we),
   .a_rdata       (a_rdata),
   .clash_pulse   (clash_pulse),
   .clash_addr    (clash_addr),
   .a_taint_pulse (a_taint_pulse),
   .a_taint_addr  (a_taint_addr),
   .b_taint_pulse (b_taint_pulse),
   .b_taint_addr  (b_taint_addr)
);

// File: tb/tdpr_dual_ram_tb_top.sv
module tdpr_dual_ram_tb_top;

   localparam int W     = 16;
   localparam int AW    = 5;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b0;
   logic [W-1:0]  a_wdata = '0;
   logic [AW-1:0] a_addr = '0;
   logic          a_we = 1'b0;
   logic [W-1:0]  b_wdata = '0;
   logic [AW-1:0] b_addr = '0;
   logic          b_we = 1'b0;
   logic [W-1:0]  a_rdata;
   logic [W-1:0]  b_rdata;
   logic          clash_pulse;
   logic [AW-1:0] clash_addr;
   logic          a_taint_pulse;
   logic [AW-1:0] a_taint_addr;
   logic          b_taint_pulse;
   logic [AW-1:0] b_taint_addr;

   always #5 clk = ~clk;

   tdpr_dual_ram dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .clk_en        (clk_en),
      .a_wdata       (a_wdata),
      .a_addr        (a_addr),
      .a_we          (a_we),
      .b_wdata       (b_wdata),
      .b_addr        (b_addr),
      .b_we          (b_we),
      .a_rdata       (a_rdata),
      .b_rdata       (b_rdata),
      .clash_pulse   (clash_pulse),
      .clash_addr    (clash_addr),
      .a_taint_pulse (a_taint_pulse),
      .a_taint_addr  (a_taint_addr),
      .b_taint_pulse (b_taint_pulse),
      .b_taint_addr  (b_taint_addr)
   );

   typedef struct {
      logic [W-1:0]  qa;
      logic [W-1:0]  qb;
      bit            vqa;
      bit            vqb;
      bit            cl;
      logic [AW-1:0] cla;
      bit            ta;
      logic [AW-1:0] taa;
      bit            tb;
      logic [AW-1:0] tba;
      string         tag;
   } exp_t;

   exp_t          sb_q[$];
   logic [W-1:0]  sh_mem [DEPTH];
   bit            sh_val [DEPTH];
   bit            sh_mark [DEPTH];
   int            n_vec = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   // Driver: applies one cycle of stimulus and predicts its result
   task automatic step(input bit en, input bit awe, input int aa, input int ad,
                       input bit bwe, input int bb, input int bd, input string tag);
      exp_t e;
      bit wa, wb, cl;
      logic [AW-1:0] xa, xb;
      xa = AW'(aa);
      xb = AW'(bb);
      @(negedge clk);
      clk_en  = en;
      a_we    = awe;
      a_addr  = xa;
      a_wdata = W'(ad);
      b_we    = bwe;
      b_addr  = xb;
      b_wdata = W'(bd);
      wa = en && awe;
      wb = en && bwe;
      cl = wa && wb && (xa == xb);
      e.qa  = sh_mem[xa];
      e.vqa = sh_val[xa];
      e.qb  = sh_mem[xb];
      e.vqb = sh_val[xb];
      e.cl  = cl;
      e.cla = cl ? xa : '0;
      e.ta  = !wa && sh_mark[xa];
      e.taa = e.ta ? xa : '0;
      e.tb  = !wb && sh_mark[xb];
      e.tba = e.tb ? xb : '0;
      e.tag = tag;
      sb_q.push_back(e);
      if (cl) begin
         sh_mem[xa]  = '0;
         sh_val[xa]  = 1'b1;
         sh_mark[xa] = 1'b1;
      end else begin
         if (wa) begin
            sh_mem[xa]  = W'(ad);
            sh_val[xa]  = 1'b1;
            sh_mark[xa] = 1'b0;
         end
         if (wb) begin
            sh_mem[xb]  = W'(bd);
            sh_val[xb]  = 1'b1;
            sh_mark[xb] = 1'b0;
         end
      end
   endtask

   task automatic rd(input int aa, input int bb, input string tag);
      step(1'b1, 1'b0, aa, 0, 1'b0, bb, 0, tag);
   endtask

   // Monitor: compares each result one settle delay after its clock edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb_q.pop_front();
            bad = 1'b0;
            if (e.vqa && a_rdata !== e.qa) bad = 1'b1;
            if (e.vqb && b_rdata !== e.qb) bad = 1'b1;
            if (clash_pulse !== e.cl || clash_addr !== e.cla) bad = 1'b1;
            if (a_taint_pulse !== e.ta || a_taint_addr !== e.taa) bad = 1'b1;
            if (b_taint_pulse !== e.tb || b_taint_addr !== e.tba) bad = 1'b1;
            n_vec++;
            if (bad) begin
               n_bad++;
               $display("FAIL %s: actual qa=%h qb=%h cl=%b/%0d ta=%b/%0d tb=%b/%0d expected qa=%h qb=%h cl=%b/%0d ta=%b/%0d tb=%b/%0d",
                        e.tag, a_rdata, b_rdata, clash_pulse, clash_addr,
                        a_taint_pulse, a_taint_addr, b_taint_pulse, b_taint_addr,
                        e.qa, e.qb, e.cl, e.cla, e.ta, e.taa, e.tb, e.tba);
            end
         end
      end
   end

   task automatic check_reset_state(input string tag);
      n_vec++;
      if (a_rdata !== '0 || b_rdata !== '0 || clash_pulse !== 1'b0 || clash_addr !== '0 ||
          a_taint_pulse !== 1'b0 || a_taint_addr !== '0 ||
          b_taint_pulse !== 1'b0 || b_taint_addr !== '0) begin
         n_bad++;
         $display("FAIL %s: actual qa=%h qb=%h cl=%b ta=%b tb=%b expected all zero",
                  tag, a_rdata, b_rdata, clash_pulse, a_taint_pulse, b_taint_pulse);
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      clk_en = 1'b0;
      a_we   = 1'b0;
      b_we   = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         sh_mem[i]  = '0;
         sh_val[i]  = 1'b0;
         sh_mark[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      // R10: outputs held at zero during reset
      check_reset_state("R10 reset");
      // R11: data port width from format parameters
      n_vec++;
      if ($bits(a_rdata) != 16 || $bits(b_wdata) != 16) begin
         n_bad++;
         $display("FAIL R11: actual width %0d expected 16", $bits(a_rdata));
      end
      rst_n = 1'b1;

      // R4: fill memory, both ports writing distinct addresses
      for (int i = 0; i < DEPTH / 2; i++)
         step(1'b1, 1'b1, 2 * i, 16'h1000 + 2 * i, 1'b1, 2 * i + 1, 16'h2000 + i, "R4 fill");
      // R1: independent reads on both ports
      for (int i = 0; i < 8; i++)
         rd(i, DEPTH - 1 - i, "R1 read");
      // R2: write with read-back of old value, then new value
      step(1'b1, 1'b1, 3, 16'hABCD, 1'b0, 3, 0, "R2 old data");
      rd(3, 3, "R2 new data");
      step(1'b1, 1'b0, 7, 0, 1'b1, 7, 16'h5A5A, "R2 old data b");
      rd(7, 7, "R2 new data b");
      // R3: writes and a would-be collision with enable low
      step(1'b0, 1'b1, 4, 16'hDEAD, 1'b1, 4, 16'hBEEF, "R3 no write");
      step(1'b0, 1'b1, 4, 16'h1111, 1'b0, 4, 0, "R3 read flows");
      rd(4, 4, "R3 unchanged");
      // R5, R6: collision on word 5
      step(1'b1, 1'b1, 5, 16'h7777, 1'b1, 5, 16'h8888, "R5 R6 collision");
      rd(5, 5, "R5 R7 zero and taint both ports");
      // R9 and R8: A cleans word 5 while B reads it
      step(1'b1, 1'b1, 5, 16'h4242, 1'b0, 5, 0, "R9 R7 writer silent reader flagged");
      rd(5, 5, "R8 cleared");
      // R7 on port B only
      step(1'b1, 1'b1, 12, 16'h0101, 1'b1, 12, 16'h0202, "R6 collision 12");
      rd(2, 12, "R7 taint on B");
      rd(12, 2, "R7 taint on A");
      // R3: corrupt read still reported with enable low
      step(1'b0, 1'b0, 12, 0, 1'b0, 12, 0, "R3 R7 taint with enable low");
      // R8: port B cleans word 12
      step(1'b1, 1'b0, 12, 0, 1'b1, 12, 16'h3131, "R8 B write clears");
      rd(12, 12, "R8 clean after B write");
      // R10: mark set, then reset mid-run
      step(1'b1, 1'b1, 20, 16'h9999, 1'b1, 20, 16'h6666, "R6 collision 20");
      go_idle();
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("R10 mid reset");
      for (int i = 0; i < DEPTH; i++) sh_mark[i] = 1'b0;
      rst_n = 1'b1;
      rd(20, 20, "R10 marks cleared data kept");
      // Dense random traffic on four words
      for (int i = 0; i < 300; i++)
         step(($urandom_range(7) != 0), $urandom_range(1), $urandom_range(3), $urandom_range(65535),
              $urandom_range(1), $urandom_range(3), $urandom_range(65535), "R7 random");
      go_idle();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual run still busy expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule